// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block forms the two divided comparison pulses of a frequency synthesizer loop. The feedback path counts edges of `fin_clk`, which stands in for the oscillator being controlled. A digital counter models a dual-modulus prescaler that divides by P or P+1. Behind it sit a swallow counter and a main counter. Together they divide the feedback clock by P·N + A. P is either 64 or 128, picked by `pre_small`.

At the start of each output cycle the prescaler runs at P+1 until the swallow counter has counted A prescaler cycles. It then runs at P for the remaining N−A prescaler cycles. A separate reference counter divides `osc_clk` by R. The feedback path emits a one-clock pulse on `fp` and the reference path a one-clock pulse on `fr`. The two pulses are what a phase detector compares.

The settings are ordinary inputs that may change at any time. Each counter takes its setting only at its own output-cycle boundary, so a change never produces a shortened or mixed cycle.

Top module: `pll_swallow_divider`

## Requirements
- R1: With settings held, consecutive `fp` pulses are exactly P·N + A `fin_clk` cycles apart. P is 64 when `pre_small` is 1 and 128 when it is 0.
- R2: With `swal_cnt` = 0, the `fp` period is exactly P·N cycles, and `mod_ctl` stays low for the whole cycle.
- R3: The smallest legal main count N = 16, combined with the largest legal swallow count A = N−1 = 15, gives a period of P·16 + 15.
- R4: `mod_ctl` (1 = divide by P+1) is high for the first A·(P+1) `fin_clk` cycles after each `fp` boundary edge, and low for the rest of the cycle.
- R5: `mod_ctl` changes only at the end of a prescaler cycle, and it never falls in a cycle where `fp` is high.
- R6: With `ref_cnt` held, consecutive `fr` pulses are exactly R `osc_clk` cycles apart, for R between 8 and 16383.
- R7: `fp` is high for exactly one `fin_clk` cycle per output cycle.
- R8: `fr` is high for exactly one `osc_clk` cycle per reference cycle.
- R9: A change of `swal_cnt`, `main_cnt`, `pre_small` or `ref_cnt` in the middle of a cycle leaves that cycle's length unchanged. The new value governs only the cycle that starts at the next boundary.
- R10: While `rst_n` is low, `fp`, `fr` and `mod_ctl` are all low. The first rising edge of each clock after release is a boundary, so each pulse appears one clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin_clk | input | 1 | Feedback clock to be divided (stands in for the controlled oscillator) |
| osc_clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for both paths |
| swal_cnt | input | 7 | Swallow count A, 0..127, must be below N |
| main_cnt | input | 11 | Main count N, 16..2047 |
| ref_cnt | input | 14 | Reference ratio R, 8..16383 |
| pre_small | input | 1 | 1 selects modulus 64/65, 0 selects 128/129 |
| fp | output | 1 | One-cycle feedback comparison pulse (`fin_clk` domain) |
| fr | output | 1 | One-cycle reference comparison pulse (`osc_clk` domain) |
| mod_ctl | output | 1 | Prescaler modulus control, 1 = divide by P+1 |

## Verification
Two events can fall on the same `fin_clk` edge: the end of the last prescaler cycle (an output boundary) and the loading of new settings. They collide when the settings change while a cycle is still running. The bench changes the modulus, N and A partway through a cycle and later moves them to the minimum N with the largest A. At every `fin_clk` cycle it compares `fp` and `mod_ctl` against a behavioural model. That model latches the settings only at its own boundary, so a setting that leaks in early or late shows up as a wrong pulse position or a wrong modulus window.

// File: rtl/pll_swallow_divider.sv
module pll_swallow_divider #(
  parameter int A_W  = 7,
  parameter int N_W  = 11,
  parameter int R_W  = 14,
  parameter int P_LO = 64
) (
  input  logic           fin_clk,
  input  logic           osc_clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] swal_cnt,
  input  logic [N_W-1:0] main_cnt,
  input  logic [R_W-1:0] ref_cnt,
  input  logic           pre_small,
  output logic           fp,
  output logic           fr,
  output logic           mod_ctl
);
  localparam int P_HI = 2 * P_LO;
  localparam int PC_W = $clog2(P_HI + 1);
  localparam logic [PC_W-1:0] P_LO_V = PC_W'(P_LO);
  localparam logic [PC_W-1:0] P_HI_V = PC_W'(P_HI);

  logic [PC_W-1:0] pcnt;
  logic [A_W-1:0]  acnt;
  logic [N_W-1:0]  ncnt;
  logic [R_W-1:0]  rcnt;
  logic            p_small_q;

  logic [PC_W-1:0] p_cur, p_new;
  logic [A_W-1:0]  a_nxt;
  logic            pre_end, last;

  assign p_cur   = p_small_q ? P_LO_V : P_HI_V;
  assign p_new   = pre_small ? P_LO_V : P_HI_V;
  assign pre_end = (pcnt == '0);
  assign last    = (ncnt == N_W'(1));
  assign a_nxt   = (acnt == '0) ? '0 : acnt - 1'b1;
  assign mod_ctl = (acnt != '0);

  always_ff @(posedge fin_clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      ncnt      <= N_W'(1);
      acnt      <= '0;
      p_small_q <= 1'b0;
      fp        <= 1'b0;
    end else begin
      fp <= pre_end && last;
      if (!pre_end) begin
        pcnt <= pcnt - 1'b1;
      end else if (last) begin
        ncnt      <= main_cnt;
        acnt      <= swal_cnt;
        p_small_q <= pre_small;
        pcnt      <= (swal_cnt != '0) ? p_new : p_new - 1'b1;
      end else begin
        ncnt <= ncnt - 1'b1;
        acnt <= a_nxt;
        pcnt <= (a_nxt != '0) ? p_cur : p_cur - 1'b1;
      end
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
      fr   <= 1'b0;
    end else begin
      fr   <= (rcnt == '0);
      rcnt <= (rcnt == '0) ? ref_cnt - 1'b1 : rcnt - 1'b1;
    end
  end

  AST_FP_SINGLE: assert property (@(posedge fin_clk) disable iff (!rst_n) fp |=> !fp); // R7
  AST_FR_SINGLE: assert property (@(posedge osc_clk) disable iff (!rst_n) fr |=> !fr); // R8
  AST_MOD_HOLD_IN_PRESCALE: assert property (@(posedge fin_clk) disable iff (!rst_n) (pcnt != '0) |=> $stable(mod_ctl)); // R5
  AST_MOD_FALL_MIDCYCLE: assert property (@(posedge fin_clk) disable iff (!rst_n) $fell(mod_ctl) |-> !fp); // R5
  AST_MAIN_NONZERO: assert property (@(posedge fin_clk) disable iff (!rst_n) ncnt != '0); // R3
endmodule

// File: tb/test_pll_swallow_divider.sv
module test_pll_swallow_divider;
  logic        fin_clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic [6:0]  swal_cnt;
  logic [10:0] main_cnt;
  logic [13:0] ref_cnt;
  logic        pre_small;
  logic        fp, fr, mod_ctl;

  int checks = 0, failures = 0;
  string tag = "R10";
  bit    done = 1'b0;

  pll_swallow_divider i_pll_swallow_divider (
    .fin_clk(fin_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .swal_cnt(swal_cnt), .main_cnt(main_cnt), .ref_cnt(ref_cnt),
    .pre_small(pre_small), .fp(fp), .fr(fr), .mod_ctl(mod_ctl)
  );

  always #5 fin_clk = ~fin_clk;
  always #7 osc_clk = ~osc_clk;

  int  f_rem, f_m, f_a, f_p;
  bit  f_exp;
  always @(posedge fin_clk) begin
    if (!rst_n) begin
      f_rem = 1; f_m = 0; f_a = 0; f_p = 128; f_exp = 1'b0;
    end else begin
      f_rem--; f_m++;
      if (f_rem == 0) begin
        f_p   = pre_small ? 64 : 128;
        f_a   = swal_cnt;
        f_rem = f_p * main_cnt + swal_cnt;
        f_m   = 0;
        f_exp = 1'b1;
      end else f_exp = 1'b0;
    end
  end

  int r_rem;
  bit r_exp;
  always @(posedge osc_clk) begin
    if (!rst_n) begin
      r_rem = 1; r_exp = 1'b0;
    end else begin
      r_rem--;
      if (r_rem == 0) begin r_rem = ref_cnt; r_exp = 1'b1; end
      else r_exp = 1'b0;
    end
  end

  always @(negedge fin_clk) if (!done) begin
    bit em;
    em = (f_m < f_a * (f_p + 1));
    if (!rst_n) begin
      checks++;
      if (fp !== 1'b0 || mod_ctl !== 1'b0) begin
        failures++;
        $display("FAIL R10 fp=%b mod_ctl=%b expected 0 0 in reset", fp, mod_ctl);
      end
    end else begin
      checks++;
      if (fp !== f_exp) begin
        failures++;
        $display("FAIL %s R7 fp=%b expected %b at t=%0t", tag, fp, f_exp, $time);
      end
      checks++;
      if (mod_ctl !== em) begin
        failures++;
        $display("FAIL R4/R5 (%s) mod_ctl=%b expected %b at t=%0t", tag, mod_ctl, em, $time);
      end
    end
  end

  always @(negedge osc_clk) if (!done) begin
    checks++;
    if (!rst_n) begin
      if (fr !== 1'b0) begin
        failures++;
        $display("FAIL R10 fr=%b expected 0 in reset", fr);
      end
    end else if (fr !== r_exp) begin
      failures++;
      $display("FAIL R6 R8 (%s) fr=%b expected %b at t=%0t", tag, fr, r_exp, $time);
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge fin_clk);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    pre_small = 1'b1; main_cnt = 11'd16; swal_cnt = 7'd5; ref_cnt = 14'd8;
    run(5);
    rst_n = 1'b1;
    tag = "R1";
    run(3500);
    tag = "R9";
    pre_small = 1'b0; main_cnt = 11'd20; swal_cnt = 7'd0; ref_cnt = 14'd100;
    run(3000);
    tag = "R2";
    run(5300);
    tag = "R9";
    pre_small = 1'b1; main_cnt = 11'd16; swal_cnt = 7'd15; ref_cnt = 14'd13;
    run(2700);
    tag = "R3";
    run(2200);
    tag = "R9";
    pre_small = 1'b0; main_cnt = 11'd17; swal_cnt = 7'd9; ref_cnt = 14'd2000;
    run(2300);
    tag = "R1";
    run(4500);
    finish_up();
  end

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired, run hung");
    finish_up();
  end
endmodule